// File: doc/BRIEF.md
# Monitor Channel Handshake Controller

This block is the device end of a byte-wide monitor channel that travels inside a framed time-division serial link. Once per frame, an external framer gives a one-cycle strobe. The block then samples the downstream monitor byte and the two active-low handshake bits from the host: a transmit flag (MX) and a receive flag (MR). It answers with an upstream monitor byte and its own MX and MR bits, all held in registers until the next frame.

A host message is a sequence of bytes, and the host sends each one under a per-frame MX/MR handshake. Byte 0 is a command. Bit 7 of the command selects read (1) or write (0). Bits 6:0 give the number of bytes a read returns, minus one. Byte 1 is the starting register address. On a write, every later byte is stored at the current address, and the address then steps by one. On a read, the block takes the whole command with its MR bit, waits for the end of the message, and then returns data bytes under its own MX bit, with the host acknowledging on downstream MR. A non-idle downstream byte seen while the block is sending aborts the transfer.

The register file is outside the block. The block reaches it through a single port with a one-cycle write strobe and a synchronous read: data comes back in the clock after the read strobe.

Top module: `mon_hs_ctrl`

## Requirements
- R1: After a synchronous reset, up_mx_n and up_mr_n are 1, up_mon is 0xFF, and abort_o, reg_wr and reg_rd are 0.
- R2: Protocol state advances only on clocks with frame_stb high. up_mr_n, abort_o and reg_wr change only in the clock after a strobe.
- R3: When idle, a strobe with dn_mx_n = 0 captures dn_mon as the command byte, and up_mr_n goes to 0 in the next clock.
- R4: While receiving, dn_mx_n being 1 at one strobe and 0 at the next delivers a new byte. up_mr_n is released to 1 for one frame and driven back to 0 at the following strobe.
- R5: While receiving, dn_mx_n at 1 on two consecutive strobes ends the message, and up_mr_n returns to 1.
- R6: up_mon is 0xFF whenever up_mx_n is 1, and up_mx_n and up_mr_n are never both 0.
- R7: In a write message (command bit 7 = 0), byte 1 sets the address. Each later byte gives a one-cycle reg_wr with reg_wdata equal to that byte, and the address then increments, wrapping at 2^AW.
- R8: A read message (command bit 7 = 1, bits 6:0 = count minus one) with at least two bytes gives a one-cycle reg_rd at the current address in the clock after its end-of-message strobe. Two clocks after reg_rd, up_mon carries that clock's reg_rdata value and up_mx_n is 0.
- R9: While sending, dn_mr_n being 1 at one strobe and 0 at the next acknowledges the byte: up_mx_n becomes 1 and up_mon becomes 0xFF. At the next strobe, the following address is read if bytes remain. After the last byte, up_mx_n stays 1 for two frames before the block is idle.
- R10: A strobe with dn_mon ≠ 0xFF while the block is sending or between its sent bytes raises abort_o for one clock, sets up_mx_n and up_mr_n to 1 and up_mon to 0xFF, and drops the message.
- R11: After an abort, dn_mx_n = 0 starts nothing until two consecutive strobes have seen both dn_mx_n and dn_mr_n at 1.
- R12: A message with fewer than two bytes makes no register access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle pulse per frame; downstream fields are valid in this cycle |
| dn_mon | input | 8 | Downstream monitor byte |
| dn_mx_n | input | 1 | Downstream transmit flag, active low |
| dn_mr_n | input | 1 | Downstream receive flag, active low |
| up_mon | output | 8 | Upstream monitor byte |
| up_mx_n | output | 1 | Upstream transmit flag, active low |
| up_mr_n | output | 1 | Upstream receive flag, active low |
| abort_o | output | 1 | One-cycle abort pulse |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe |
| reg_addr | output | AW | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data, valid one clock after reg_rd |

## Verification
The hardest condition to reach from the ports is the recovery after an abort. To get there, a read must first be completed and must be in its send phase, and only then may a non-idle byte appear. After that the idle count has to be broken and restarted before a start condition is honoured. The stimulus sends a read command, lets one data byte go out, corrupts the downstream byte, and then inserts a frame with MX low and a frame with MX high between idle frames. This shows that neither frame starts a transfer until two clean idle frames in a row have passed. Address wrap is reached by a write that starts at the top address.

// File: rtl/mon_hs_pkg.sv
package mon_hs_pkg;
  localparam int MON_W = 8;
  localparam logic [MON_W-1:0] MON_IDLE = 8'hFF;

  typedef enum logic [3:0] {
    S_IDLE, S_RX, S_REACK, S_FETCH, S_LOAD, S_SEND, S_GAP, S_END, S_ABORT
  } mon_st_e;
endpackage

// File: rtl/mon_edge_track.sv
module mon_edge_track (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  input  logic mx_n,
  input  logic mr_n,
  output logic mx_fall,
  output logic mr_fall,
  output logic both_hi
);
  logic mx_q, mr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mx_q <= 1'b1;
      mr_q <= 1'b1;
    end else if (stb) begin
      mx_q <= mx_n;
      mr_q <= mr_n;
    end
  end

  // high in the previous frame, low in this one
  assign mx_fall = mx_q & ~mx_n;
  assign mr_fall = mr_q & ~mr_n;
  assign both_hi = mx_n & mr_n;
endmodule

// File: rtl/mon_addr_ctr.sv
module mon_addr_ctr #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          inc,
  input  logic [AW-1:0] load_val,
  output logic [AW-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (load) addr <= load_val;
    else if (inc)  addr <= addr + 1'b1;
  end
endmodule

// File: rtl/mon_hs_ctrl.sv
module mon_hs_ctrl
  import mon_hs_pkg::*;
#(
  parameter int AW         = 8,
  parameter int EOM_FRAMES = 2,
  parameter int ABT_FRAMES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_stb,
  input  logic [7:0]    dn_mon,
  input  logic          dn_mx_n,
  input  logic          dn_mr_n,
  output logic [7:0]    up_mon,
  output logic          up_mx_n,
  output logic          up_mr_n,
  output logic          abort_o,
  output logic          reg_wr,
  output logic          reg_rd,
  output logic [AW-1:0] reg_addr,
  output logic [7:0]    reg_wdata,
  input  logic [7:0]    reg_rdata
);
  localparam int RUN_MAX = (EOM_FRAMES > ABT_FRAMES) ? EOM_FRAMES : ABT_FRAMES;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);
  localparam logic [RUN_W-1:0] EOM_LAST = RUN_W'(EOM_FRAMES - 1);
  localparam logic [RUN_W-1:0] ABT_LAST = RUN_W'(ABT_FRAMES - 1);

  mon_st_e          st;
  logic [RUN_W-1:0] run;
  logic [1:0]       nrx;
  logic             is_rd;
  logic [6:0]       left;
  logic [AW-1:0]    addr;
  logic             mx_fall, mr_fall, both_hi;
  logic             bad, tx_phase, go_abort, rx_new, eom, wr_go, rd_go, addr_ld, addr_inc;

  mon_edge_track u_edge (
    .clk(clk), .rst(rst), .stb(frame_stb), .mx_n(dn_mx_n), .mr_n(dn_mr_n),
    .mx_fall(mx_fall), .mr_fall(mr_fall), .both_hi(both_hi)
  );

  mon_addr_ctr #(.AW(AW)) u_addr (
    .clk(clk), .rst(rst), .load(addr_ld), .inc(addr_inc),
    .load_val(AW'(dn_mon)), .addr(addr)
  );

  always_comb begin
    bad      = (dn_mon != MON_IDLE);
    tx_phase = (st == S_SEND) || (st == S_GAP) || (st == S_END);
    go_abort = frame_stb && tx_phase && bad;
    rx_new   = frame_stb && (st == S_RX) && mx_fall;
    eom      = frame_stb && (st == S_RX) && dn_mx_n && (run == EOM_LAST);
    wr_go    = rx_new && (nrx == 2'd2) && !is_rd;
    rd_go    = (eom && is_rd && (nrx == 2'd2)) ||
               (frame_stb && (st == S_GAP) && !bad && (left != 7'd0));
    addr_ld  = rx_new && (nrx == 2'd1);
    addr_inc = wr_go || rd_go;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      run       <= '0;
      nrx       <= '0;
      is_rd     <= 1'b0;
      left      <= '0;
      up_mon    <= MON_IDLE;
      up_mx_n   <= 1'b1;
      up_mr_n   <= 1'b1;
      abort_o   <= 1'b0;
      reg_wr    <= 1'b0;
      reg_rd    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
    end else begin
      abort_o <= 1'b0;
      reg_wr  <= 1'b0;
      reg_rd  <= 1'b0;
      if (wr_go) begin
        reg_wr    <= 1'b1;
        reg_addr  <= addr;
        reg_wdata <= dn_mon;
      end
      if (rd_go) begin
        reg_rd   <= 1'b1;
        reg_addr <= addr;
      end
      if (st == S_FETCH) begin
        st <= S_LOAD;
      end else if (st == S_LOAD) begin
        up_mon  <= reg_rdata;
        up_mx_n <= 1'b0;
        st      <= S_SEND;
      end else if (go_abort) begin
        abort_o <= 1'b1;
        up_mx_n <= 1'b1;
        up_mr_n <= 1'b1;
        up_mon  <= MON_IDLE;
        run     <= '0;
        st      <= S_ABORT;
      end else if (frame_stb) begin
        case (st)
          S_IDLE: if (!dn_mx_n) begin
            nrx     <= 2'd1;
            is_rd   <= dn_mon[7];
            left    <= dn_mon[6:0];
            up_mr_n <= 1'b0;
            run     <= '0;
            st      <= S_RX;
          end
          S_RX: begin
            if (mx_fall) begin
              if (nrx != 2'd2) nrx <= nrx + 2'd1;
              up_mr_n <= 1'b1;
              run     <= '0;
              st      <= S_REACK;
            end else if (dn_mx_n) begin
              if (eom) begin
                up_mr_n <= 1'b1;
                run     <= '0;
                st      <= rd_go ? S_FETCH : S_IDLE;
              end else begin
                run <= run + 1'b1;
              end
            end else begin
              run <= '0;
            end
          end
          S_REACK: begin
            up_mr_n <= 1'b0;
            run     <= '0;
            st      <= S_RX;
          end
          S_SEND: if (mr_fall) begin
            up_mx_n <= 1'b1;
            up_mon  <= MON_IDLE;
            st      <= S_GAP;
          end
          S_GAP: begin
            if (rd_go) begin
              left <= left - 7'd1;
              st   <= S_FETCH;
            end else begin
              st <= S_END;
            end
          end
          S_END: st <= S_IDLE;
          S_ABORT: begin
            if (!both_hi)              run <= '0;
            else if (run == ABT_LAST)  begin run <= '0; st <= S_IDLE; end
            else                       run <= run + 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mon_hs_ctrl_chk.sv
module mon_hs_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       frame_stb,
  input logic [7:0] up_mon,
  input logic       up_mx_n,
  input logic       up_mr_n,
  input logic       abort_o,
  input logic       reg_wr,
  input logic       reg_rd
);
  // R6: one side of the handshake at a time
  p_single_flag_r6: assert property (@(posedge clk) disable iff (rst)
    !(!up_mx_n && !up_mr_n));

  // R6: idle byte whenever not sending
  p_idle_byte_r6: assert property (@(posedge clk) disable iff (rst)
    up_mx_n |-> (up_mon == 8'hFF));

  // R2: receive flag moves only after a frame strobe
  p_mr_on_frame_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(up_mr_n) |-> $past(frame_stb));

  // R7: writes follow a strobe and are single-cycle
  p_wr_on_frame_r7: assert property (@(posedge clk) disable iff (rst)
    reg_wr |-> ($past(frame_stb) && !reg_rd));

  // R8: read strobe is one cycle, data is on the line two clocks later
  p_rd_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> !reg_rd);
  p_rd_to_send_r8: assert property (@(posedge clk) disable iff (rst)
    reg_rd |-> ##2 !up_mx_n);

  // R10: abort releases the line and is a single pulse
  p_abort_release_r10: assert property (@(posedge clk) disable iff (rst)
    abort_o |-> (up_mx_n && up_mr_n && up_mon == 8'hFF));
  p_abort_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    abort_o |=> !abort_o);
endmodule

bind mon_hs_ctrl mon_hs_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .frame_stb(frame_stb), .up_mon(up_mon),
  .up_mx_n(up_mx_n), .up_mr_n(up_mr_n), .abort_o(abort_o),
  .reg_wr(reg_wr), .reg_rd(reg_rd)
);

// File: tb/mon_hs_ctrl_test.sv
`timescale 1ns/1ps
module mon_hs_ctrl_test;
  localparam int FP = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_stb = 1'b0;
  logic [7:0] dn_mon = 8'hFF;
  logic       dn_mx_n = 1'b1;
  logic       dn_mr_n = 1'b1;
  logic [7:0] up_mon;
  logic       up_mx_n, up_mr_n, abort_o, reg_wr, reg_rd;
  logic [7:0] reg_addr, reg_wdata;
  logic [7:0] reg_rdata = 8'h00;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int wr_seen = 0;
  int abort_seen = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mon_hs_ctrl uut (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .dn_mon(dn_mon),
    .dn_mx_n(dn_mx_n), .dn_mr_n(dn_mr_n), .up_mon(up_mon), .up_mx_n(up_mx_n),
    .up_mr_n(up_mr_n), .abort_o(abort_o), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // register file seen by the block, and the model's own copy
  logic [7:0] mem   [256];
  logic [7:0] mem_m [256];
  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]   = 8'(i * 7 + 3);
      mem_m[i] = 8'(i * 7 + 3);
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (reg_wr) begin mem[reg_addr] <= reg_wdata; wr_seen <= wr_seen + 1; end
    if (reg_rd) reg_rdata <= mem[reg_addr];
    if (abort_o) abort_seen <= abort_seen + 1;
  end

  // ---------------- behavioural reference ----------------
  logic [7:0] e_mon;
  logic       e_mx, e_mr, e_abort, e_wr, e_rd;
  logic [7:0] e_addr, e_wdata;
  int         md;          // 0 idle 1 rx 2 reack 3 fetch 4 load 5 send 6 gap 7 end 8 abort-wait
  logic [7:0] rxq[$];
  int         hi, left, ptr, rptr;
  bit         pmx, pmr, fall_x, fall_r, odd;

  task automatic model_abort();
    e_abort = 1; e_mx = 1; e_mr = 1; e_mon = 8'hFF; md = 8; hi = 0;
  endtask

  task automatic model_fetch();
    e_rd = 1; e_addr = 8'(ptr); rptr = ptr; ptr = (ptr + 1) % 256; md = 3;
  endtask

  always @(posedge clk) begin
    e_abort = 0; e_wr = 0; e_rd = 0;
    if (rst) begin
      md = 0; e_mx = 1; e_mr = 1; e_mon = 8'hFF; pmx = 1; pmr = 1;
      hi = 0; left = 0; ptr = 0; rptr = 0; e_addr = 0; e_wdata = 0;
      rxq.delete();
    end else if (md == 3) begin
      md = 4;
    end else if (md == 4) begin
      e_mon = mem_m[rptr]; e_mx = 0; md = 5;
    end else if (frame_stb) begin
      fall_x = pmx && !dn_mx_n;
      fall_r = pmr && !dn_mr_n;
      odd    = (dn_mon != 8'hFF);
      if ((md == 5 || md == 6 || md == 7) && odd) model_abort();
      else begin
        case (md)
          0: if (!dn_mx_n) begin rxq.delete(); rxq.push_back(dn_mon); e_mr = 0; md = 1; hi = 0; end
          1: begin
            if (fall_x) begin
              rxq.push_back(dn_mon); e_mr = 1; md = 2; hi = 0;
              if (rxq.size() == 2) ptr = dn_mon;
              else if (!rxq[0][7]) begin
                e_wr = 1; e_addr = 8'(ptr); e_wdata = dn_mon;
                mem_m[ptr] = dn_mon; ptr = (ptr + 1) % 256;
              end
            end else if (dn_mx_n) begin
              hi++;
              if (hi >= 2) begin
                e_mr = 1; hi = 0;
                if (rxq[0][7] && rxq.size() >= 2) begin left = rxq[0][6:0]; model_fetch(); end
                else md = 0;
              end
            end else hi = 0;
          end
          2: begin e_mr = 0; md = 1; hi = 0; end
          5: if (fall_r) begin e_mx = 1; e_mon = 8'hFF; md = 6; end
          6: if (left > 0) begin left--; model_fetch(); end else md = 7;
          7: md = 0;
          8: begin
            if (dn_mx_n && dn_mr_n) begin hi++; if (hi >= 2) begin md = 0; hi = 0; end end
            else hi = 0;
          end
          default: ;
        endcase
      end
      pmx = dn_mx_n; pmr = dn_mr_n;
    end
  end

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  // compare against the model on every clock
  always @(negedge clk) begin
    if (cyc >= 1 && !done) begin
      check8("R2/R3/R4/R5 up_mr_n", 8'(up_mr_n), 8'(e_mr));
      check8("R8/R9 up_mx_n", 8'(up_mx_n), 8'(e_mx));
      check8("R6/R8 up_mon", up_mon, e_mon);
      check8("R10 abort_o", 8'(abort_o), 8'(e_abort));
      check8("R7/R12 reg_wr", 8'(reg_wr), 8'(e_wr));
      check8("R8 reg_rd", 8'(reg_rd), 8'(e_rd));
      if (e_wr || e_rd) check8("R7/R8 reg_addr", reg_addr, e_addr);
      if (e_wr) check8("R7 reg_wdata", reg_wdata, e_wdata);
    end
  end

  task automatic frame(input logic mx, input logic mr, input logic [7:0] b);
    @(negedge clk);
    dn_mx_n = mx; dn_mr_n = mr; dn_mon = b; frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
    repeat (FP - 2) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    frame(1'b0, 1'b1, b);
    frame(1'b0, 1'b1, b);
    frame(1'b0, 1'b1, b);
    frame(1'b1, 1'b1, 8'hFF);
  endtask

  task automatic end_msg();
    frame(1'b1, 1'b1, 8'hFF);
    frame(1'b1, 1'b1, 8'hFF);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  int wr_before;
  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check8("R1 up_mx_n", 8'(up_mx_n), 8'h01);
    check8("R1 up_mr_n", 8'(up_mr_n), 8'h01);
    check8("R1 up_mon", up_mon, 8'hFF);
    check8("R1 strobes", {5'd0, abort_o, reg_wr, reg_rd}, 8'h00);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // write 3 bytes from address 0x10 (R3, R4, R5, R7)
    send_byte(8'h00); send_byte(8'h10);
    send_byte(8'hAA); send_byte(8'hBB); send_byte(8'hCC);
    end_msg();
    check8("R7 mem[10]", mem[8'h10], 8'hAA);
    check8("R7 mem[11]", mem[8'h11], 8'hBB);
    check8("R7 mem[12]", mem[8'h12], 8'hCC);

    // address wrap (R7)
    send_byte(8'h00); send_byte(8'hFF); send_byte(8'h11); send_byte(8'h22);
    end_msg();
    check8("R7 wrap mem[FF]", mem[8'hFF], 8'h11);
    check8("R7 wrap mem[00]", mem[8'h00], 8'h22);

    // read 3 bytes from 0x10 (R8, R9)
    send_byte(8'h82); send_byte(8'h10);
    frame(1'b1, 1'b1, 8'hFF);
    for (int k = 0; k < 3; k++) begin
      frame(1'b1, 1'b1, 8'hFF);
      check8("R8 sending flag", 8'(up_mx_n), 8'h00);
      check8("R8 read data", up_mon, (k == 0) ? 8'hAA : (k == 1) ? 8'hBB : 8'hCC);
      frame(1'b1, 1'b0, 8'hFF);
      check8("R9 released after ack", {up_mx_n, up_mon[6:0]}, 8'hFF);
      frame(1'b1, 1'b1, 8'hFF);
      frame(1'b1, 1'b1, 8'hFF);
    end
    check8("R9 idle after last byte", 8'(up_mx_n), 8'h01);

    // abort during a read (R10) and recovery (R11)
    send_byte(8'h81); send_byte(8'h30);
    frame(1'b1, 1'b1, 8'hFF);
    frame(1'b1, 1'b1, 8'hFF);
    check8("R10 no abort yet", 8'(abort_seen), 8'h00);
    frame(1'b1, 1'b1, 8'h12);
    check8("R10 abort pulse", 8'(abort_seen), 8'h01);
    check8("R10 lines released", {up_mx_n, up_mr_n}, 8'h03);
    frame(1'b1, 1'b1, 8'hFF);
    frame(1'b0, 1'b1, 8'h55);
    check8("R11 start ignored", 8'(up_mr_n), 8'h01);
    frame(1'b1, 1'b1, 8'hFF);
    frame(1'b0, 1'b1, 8'h77);
    check8("R11 start ignored again", 8'(up_mr_n), 8'h01);
    frame(1'b1, 1'b1, 8'hFF);
    frame(1'b1, 1'b1, 8'hFF);

    // single-byte message: accepted, no register access (R11, R3, R12)
    wr_before = wr_seen;
    frame(1'b0, 1'b1, 8'h00);
    check8("R11/R3 start honoured", 8'(up_mr_n), 8'h00);
    frame(1'b1, 1'b1, 8'hFF);
    frame(1'b1, 1'b1, 8'hFF);
    check8("R12 no write", 8'(wr_seen - wr_before), 8'h00);
    check8("R5 released", 8'(up_mr_n), 8'h01);
    end_msg();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule